// File: doc/BRIEF.md
# Stream to XGMII Transmit Encapsulator

This block turns client Ethernet frames into a 10-gigabit media independent interface (XGMII) transmit stream. Frames enter on a 64-bit AXI4-Stream-style port, one beat per clock. The client supplies the frame check sequence inside the payload. Each frame always starts in lane 0. On the wire it is wrapped as follows: a start word carrying the start control character, the preamble and the delimiter; then the client bytes; then a terminate character. After the terminate comes an inter-packet gap of idle characters before the next frame may begin.

The client sees back-pressure only at frame edges. The ready signal stays low while the start word is formed and while the gap runs. Inside a frame, one beat is accepted on every cycle. A bad-frame flag on the last beat is carried to the line as an XGMII error character, so the far end discards the frame.

Top module: `xgenc_top`

## Requirements
- R1: During and straight after reset, the output is an idle word: every lane holds 0x07 with its control bit set, and `s_tready` is low.
- R2: When `s_tvalid` is seen while the encapsulator is idle, the next output word is the start word, and `s_tready` stays low in the cycle that forms it. Lane 0 holds 0xFB as a control character. Lanes 1 to 6 hold 0x55 and lane 7 holds 0xD5, all as data. The control field is therefore 0x01.
- R3: An accepted beat that is not the last one appears unchanged one cycle later, with all control bits clear.
- R4: On a last beat with n valid bytes (n from 1 to 7), lanes 0 to n-1 carry the client bytes as data. Lane n carries the terminate 0xFD as a control character. Every higher lane carries idle 0x07 as a control character.
- R5: On a last beat with all 8 bytes valid, the bytes pass through as data. The following word carries 0xFD in lane 0 and 0x07 in lanes 1 to 7, all as control characters.
- R6: When `s_tuser` is high on the last beat, lane 0 of that output word is replaced by the error character 0xFE with its control bit set. When `s_tuser` is high on any other beat, it has no effect.
- R7: Frames are separated by at least 12 idle bytes, counting the terminate lane. With back-to-back input, the number of all-idle words after the word that holds the terminate is fixed. It is one word when the last beat held 1 to 4 bytes, two words for 5 to 7 bytes, and one word after the terminate word for a full last beat. `s_tready` is low from the accept of the last beat until the next frame's body.
- R8: If `s_tvalid` drops while a frame body is in progress, that cycle outputs a word of 0xFE in every lane with all control bits set, and the frame then continues.
- R9: Byte lane i is `xgmii_txd[8i+7:8i]`, and its control bit is `xgmii_txc[i]`. The input byte enables in `s_tkeep` are contiguous from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stream and the XGMII |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 64 | Client frame bytes, lane 0 first |
| s_tkeep | input | 8 | Byte enables, contiguous from lane 0 |
| s_tvalid | input | 1 | Beat present |
| s_tready | output | 1 | Beat accepted when high together with s_tvalid |
| s_tlast | input | 1 | Last beat of the frame |
| s_tuser | input | 1 | Bad frame, honoured only with s_tlast |
| xgmii_txd | output | 64 | XGMII transmit data |
| xgmii_txc | output | 8 | XGMII transmit control, one bit per lane |

## Verification
Frames of 1 to 16 bytes are sent back to back, so every last-beat fill from one to eight bytes occurs both alone and after a full beat. This separates where the terminate lands and how many gap words follow. Bad-frame flags on last beats, both full and partial, show the error substitution. The same flag on a middle beat shows that it is ignored. A single dropped `s_tvalid` inside a body, and a pause between frames, show the error word and the stretching of the idle stream. Longer multi-beat frames confirm that body words pass through untouched.

// File: rtl/xgenc_pkg.sv
// Shared constants and types for the XGMII transmit encapsulator.
// Assumes byte-wide lanes and the standard XGMII control code values.
package xgenc_pkg;

    localparam logic [7:0] XG_IDLE  = 8'h07;
    localparam logic [7:0] XG_START = 8'hFB;
    localparam logic [7:0] XG_TERM  = 8'hFD;
    localparam logic [7:0] XG_ERROR = 8'hFE;
    localparam logic [7:0] XG_PRE   = 8'h55;
    localparam logic [7:0] XG_SFD   = 8'hD5;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BODY,
        SQ_TERM,
        SQ_GAP
    } seq_state_t;

    // Number of whole idle words still needed once idle_have gap bytes are on the line.
    function automatic int gap_words(input int lanes, input int min_gap, input int idle_have);
        if (min_gap <= idle_have) return 0;
        return (min_gap - idle_have + lanes - 1) / lanes;
    endfunction

endpackage

// File: rtl/xgenc_tail.sv
// Builds the XGMII word for the last beat of a frame: client bytes, then
// terminate, then idle fill. It also reports how many idle words must follow.
// Assumes keep is contiguous from lane 0 and has at least one bit set.
module xgenc_tail
    import xgenc_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int MIN_GAP = 12,
    parameter int GW      = 2
) (
    input  logic [LANES*8-1:0] data,
    input  logic [LANES-1:0]   keep,
    input  logic               bad,
    output logic [LANES*8-1:0] tail_d,
    output logic [LANES-1:0]   tail_c,
    output logic               full,
    output logic [GW-1:0]      gap_need
);
    localparam int CW = $clog2(LANES + 1);

    logic [CW-1:0] nvalid;

    // Per-lane selection between client byte, error, terminate and idle.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic boundary;
        logic lane_bad;
        if (i == 0) begin : g_first
            assign boundary = !keep[0];
            assign lane_bad = bad;
        end else begin : g_rest
            assign boundary = !keep[i] && keep[i-1];
            assign lane_bad = 1'b0;
        end

        // Choose this lane's byte and control bit.
        always_comb begin
            if (keep[i] && lane_bad) begin
                tail_d[i*8 +: 8] = XG_ERROR;
                tail_c[i]        = 1'b1;
            end else if (keep[i]) begin
                tail_d[i*8 +: 8] = data[i*8 +: 8];
                tail_c[i]        = 1'b0;
            end else if (boundary) begin
                tail_d[i*8 +: 8] = XG_TERM;
                tail_c[i]        = 1'b1;
            end else begin
                tail_d[i*8 +: 8] = XG_IDLE;
                tail_c[i]        = 1'b1;
            end
        end
    end

    // Count valid bytes of the last beat.
    always_comb begin
        nvalid = '0;
        for (int k = 0; k < LANES; k++) begin
            nvalid = nvalid + CW'(keep[k]);
        end
    end

    assign full = &keep;

    // Idle words still owed after this word's terminate and idle lanes.
    always_comb begin
        gap_need = GW'(gap_words(LANES, MIN_GAP, LANES - int'(nvalid)));
    end

endmodule

// File: rtl/xgenc_seq.sv
// Frame sequencer: issues the start word, passes body beats, places the
// terminate and holds the gap. Registered outputs; synchronous active-low reset.
// Assumes the start word is exactly eight lanes wide (one start, six preamble, one SFD).
module xgenc_seq
    import xgenc_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int GW       = 2,
    parameter int FULL_GAP = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES*8-1:0] tdata,
    input  logic               tvalid,
    input  logic               tlast,
    input  logic [LANES*8-1:0] tail_d,
    input  logic [LANES-1:0]   tail_c,
    input  logic               tail_full,
    input  logic [GW-1:0]      tail_gap,
    output logic               tready,
    output logic [LANES*8-1:0] txd,
    output logic [LANES-1:0]   txc
);
    localparam int DW = LANES * 8;

    function automatic logic [DW-1:0] mk_start();
        logic [DW-1:0] w;
        for (int i = 0; i < LANES; i++) begin
            if (i == 0)              w[i*8 +: 8] = XG_START;
            else if (i == LANES - 1) w[i*8 +: 8] = XG_SFD;
            else                     w[i*8 +: 8] = XG_PRE;
        end
        return w;
    endfunction

    localparam logic [DW-1:0]    START_D = mk_start();
    localparam logic [LANES-1:0] START_C = LANES'(1);
    localparam logic [DW-1:0]    IDLE_D  = {LANES{XG_IDLE}};
    localparam logic [DW-1:0]    TERM_D  = {{(LANES-1){XG_IDLE}}, XG_TERM};
    localparam logic [DW-1:0]    ERR_D   = {LANES{XG_ERROR}};

    seq_state_t    state;
    logic [GW-1:0] gap_cnt;

    // Accept client beats only while a frame body is open.
    assign tready = (state == SQ_BODY);

    // Advance the frame sequence and register the outgoing XGMII word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            txd     <= IDLE_D;
            txc     <= '1;
            gap_cnt <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (tvalid) begin
                        txd   <= START_D;
                        txc   <= START_C;
                        state <= SQ_BODY;
                    end else begin
                        txd <= IDLE_D;
                        txc <= '1;
                    end
                end
                SQ_BODY: begin
                    if (!tvalid) begin
                        txd <= ERR_D;
                        txc <= '1;
                    end else if (!tlast) begin
                        txd <= tdata;
                        txc <= '0;
                    end else begin
                        txd <= tail_d;
                        txc <= tail_c;
                        if (tail_full) begin
                            state <= SQ_TERM;
                        end else if (tail_gap == '0) begin
                            state <= SQ_IDLE;
                        end else begin
                            gap_cnt <= tail_gap;
                            state   <= SQ_GAP;
                        end
                    end
                end
                SQ_TERM: begin
                    txd <= TERM_D;
                    txc <= '1;
                    if (FULL_GAP == 0) begin
                        state <= SQ_IDLE;
                    end else begin
                        gap_cnt <= GW'(FULL_GAP);
                        state   <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    txd     <= IDLE_D;
                    txc     <= '1;
                    gap_cnt <= gap_cnt - 1'b1;
                    if (gap_cnt <= GW'(1)) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xgenc_top.sv
// Stream to XGMII transmit encapsulator. Frames start in lane 0, get a fixed
// start/preamble/SFD word, end with a terminate and are spaced by MIN_GAP idle bytes.
// Assumes the client keeps s_tvalid high through each frame and supplies the FCS.
module xgenc_top
    import xgenc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int MIN_GAP = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic                s_tlast,
    input  logic                s_tuser,
    output logic [DATA_W-1:0]   xgmii_txd,
    output logic [DATA_W/8-1:0] xgmii_txc
);
    localparam int LANES    = DATA_W / 8;
    localparam int MAX_GAP  = gap_words(LANES, MIN_GAP, 1);
    localparam int GW       = $clog2(MAX_GAP + 2);
    localparam int FULL_GAP = gap_words(LANES, MIN_GAP, LANES);

    logic [DATA_W-1:0] tail_d;
    logic [LANES-1:0]  tail_c;
    logic              tail_full;
    logic [GW-1:0]     tail_gap;

    xgenc_tail #(
        .LANES   (LANES),
        .MIN_GAP (MIN_GAP),
        .GW      (GW)
    ) u_tail (
        .data     (s_tdata),
        .keep     (s_tkeep),
        .bad      (s_tuser),
        .tail_d   (tail_d),
        .tail_c   (tail_c),
        .full     (tail_full),
        .gap_need (tail_gap)
    );

    xgenc_seq #(
        .LANES    (LANES),
        .GW       (GW),
        .FULL_GAP (FULL_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdata     (s_tdata),
        .tvalid    (s_tvalid),
        .tlast     (s_tlast),
        .tail_d    (tail_d),
        .tail_c    (tail_c),
        .tail_full (tail_full),
        .tail_gap  (tail_gap),
        .tready    (s_tready),
        .txd       (xgmii_txd),
        .txc       (xgmii_txc)
    );

endmodule

// File: rtl/xgenc_chk.sv
// Port-level protocol checks for xgenc_top, attached with bind.
// Assumes the default lane codes from xgenc_pkg.
module xgenc_chk #(
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   s_tdata,
    input logic [DATA_W/8-1:0] s_tkeep,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic                s_tlast,
    input logic                s_tuser,
    input logic [DATA_W-1:0]   xgmii_txd,
    input logic [DATA_W/8-1:0] xgmii_txc
);
    localparam int LANES = DATA_W / 8;

    logic acc;
    assign acc = s_tvalid && s_tready;

    assert_start_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xgmii_txc == LANES'(1) && xgmii_txd[7:0] == 8'hFB) |-> $past(s_tvalid));

    assert_body_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !s_tlast) |=> (xgmii_txc == '0 && xgmii_txd == $past(s_tdata)));

    assert_term_ctrl_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && s_tlast && !s_tuser && !(&s_tkeep))
        |=> ($countones(xgmii_txc) == LANES - $countones($past(s_tkeep))));

    assert_full_term_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && s_tlast && (&s_tkeep)) |-> ##2 (xgmii_txc[0] && xgmii_txd[7:0] == 8'hFD));

    assert_bad_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && s_tlast && s_tuser) |=> (xgmii_txc[0] && xgmii_txd[7:0] == 8'hFE));

    assert_gap_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && s_tlast) |=> (!s_tready ##1 !s_tready));

    assert_hole_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready && !s_tvalid) |=> (xgmii_txc == '1 && xgmii_txd == {LANES{8'hFE}}));

endmodule

bind xgenc_top xgenc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tdata   (s_tdata),
    .s_tkeep   (s_tkeep),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .s_tlast   (s_tlast),
    .s_tuser   (s_tuser),
    .xgmii_txd (xgmii_txd),
    .xgmii_txc (xgmii_txc)
);

// File: tb/xgenc_top_test.sv
// Scoreboard bench: the driver queues the expected XGMII words for each frame,
// and the monitor compares every output word after each rising edge.
module xgenc_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] s_tdata;
    logic [7:0]  s_tkeep;
    logic        s_tvalid;
    logic        s_tready;
    logic        s_tlast;
    logic        s_tuser;
    logic [63:0] xgmii_txd;
    logic [7:0]  xgmii_txc;

    always #2 clk = ~clk;

    xgenc_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_tdata   (s_tdata),
        .s_tkeep   (s_tkeep),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .s_tlast   (s_tlast),
        .s_tuser   (s_tuser),
        .xgmii_txd (xgmii_txd),
        .xgmii_txc (xgmii_txc)
    );

    localparam logic [71:0] W_IDLE  = {8'hFF, {8{8'h07}}};
    localparam logic [71:0] W_START = {8'h01, 8'hD5, {6{8'h55}}, 8'hFB};
    localparam logic [71:0] W_TERM  = {8'hFF, {7{8'h07}}, 8'hFD};
    localparam logic [71:0] W_ERR   = {8'hFF, {8{8'hFE}}};

    logic [71:0] exp_q[$];
    string       tag_q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          mon_on = 1'b0;

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [71:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each produced word with the next expected one, or idle.
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            if (exp_q.size() != 0) begin
                check(tag_q.pop_front(), {xgmii_txc, xgmii_txd}, exp_q.pop_front());
            end else begin
                check("R7 idle between frames", {xgmii_txc, xgmii_txd}, W_IDLE);
            end
        end
    end

    function automatic logic [63:0] beat_data(input int seed, input int b);
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[j*8 +: 8] = 8'(seed + b * 8 + j);
        return d;
    endfunction

    // Wait at negedges until the current beat has been taken.
    task automatic wait_accept();
        bit ok;
        forever begin
            ok = s_tready;
            @(negedge clk);
            if (ok) break;
        end
    endtask

    // Queue a frame's expected words, then drive its beats.
    task automatic send_frame(input int len, input bit bad, input int hole_after,
                              input int ubeat, input int seed);
        int nb;
        int nl;
        logic [71:0] w;
        nb = (len + 7) / 8;
        nl = len - 8 * (nb - 1);
        push(W_START, "R2 start word");
        for (int b = 0; b < nb; b++) begin
            logic [63:0] d;
            d = beat_data(seed, b);
            if (b < nb - 1) begin
                push({8'h00, d}, (b == ubeat) ? "R6 mid-beat flag ignored" : "R3 R9 body beat");
                if (b == hole_after) push(W_ERR, "R8 valid dropped");
            end else begin
                for (int i = 0; i < 8; i++) begin
                    if (i < nl && i == 0 && bad) begin
                        w[i*8 +: 8] = 8'hFE; w[64 + i] = 1'b1;
                    end else if (i < nl) begin
                        w[i*8 +: 8] = d[i*8 +: 8]; w[64 + i] = 1'b0;
                    end else if (i == nl) begin
                        w[i*8 +: 8] = 8'hFD; w[64 + i] = 1'b1;
                    end else begin
                        w[i*8 +: 8] = 8'h07; w[64 + i] = 1'b1;
                    end
                end
                push(w, bad ? "R6 error on last beat" : (nl == 8 ? "R5 full last beat" : "R4 partial last beat"));
                if (nl == 8) push(W_TERM, "R5 terminate word");
                for (int g = 0; g < ((nl == 8 || nl <= 4) ? 1 : 2); g++) push(W_IDLE, "R7 gap word");
            end
        end
        for (int b = 0; b < nb; b++) begin
            s_tdata  = beat_data(seed, b);
            s_tlast  = (b == nb - 1);
            s_tkeep  = (b == nb - 1) ? 8'((9'h1 << nl) - 1) : 8'hFF;
            s_tuser  = ((b == nb - 1) && bad) || (b == ubeat);
            s_tvalid = 1'b1;
            wait_accept();
            if (b == hole_after) begin
                s_tvalid = 1'b0;
                @(negedge clk);
            end
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        s_tuser  = 1'b0;
        check("R7 ready low after last beat", {71'd0, s_tready}, 72'd0);
    endtask

    initial begin
        rst_n    = 1'b0;
        s_tdata  = '0;
        s_tkeep  = '0;
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        s_tuser  = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                check("R1 reset output idle", {xgmii_txc, xgmii_txd}, W_IDLE);
                check("R1 reset ready low", {71'd0, s_tready}, 72'd0);
                rst_n = 1'b1;
                @(negedge clk);
                check("R1 idle after reset", {xgmii_txc, xgmii_txd}, W_IDLE);
                mon_on = 1'b1;
                repeat (2) @(negedge clk);
                for (int len = 1; len <= 16; len++) begin
                    send_frame(len, (len % 5) == 0, (len == 11) ? 0 : -1,
                               (len == 13) ? 0 : -1, len * 7);
                end
                repeat (6) @(negedge clk);
                send_frame(24, 1'b1, 1, -1, 200);
                send_frame(8, 1'b1, -1, -1, 90);
                send_frame(20, 1'b0, -1, 1, 33);
                repeat (10) @(negedge clk);
                check("R7 all expected words seen", 72'(exp_q.size()), 72'd0);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog R1..all act=timeout exp=finished");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule